// File: doc/BRIEF.md
# Machine Cycle Fetch Sequencer

This block generates the timing skeleton of a processor core whose machine cycle lasts twelve clocks: six states, S1 to S6, each split into a first and a second phase. It tells the instruction fetch path when to read a program byte and whether that byte is kept or thrown away. It also tells the program counter when to advance, marks the last clock of each instruction, and opens a data-access window for the external data-move instruction. Opcode decoding, arithmetic and pin drivers sit outside it.

The decoder presents the instruction length in bytes, its machine-cycle count and a data-move flag. The sequencer captures them once per instruction, on the clock edge that ends S1P1 of the first machine cycle. Fetch opportunities occur at S1P1 and S4P1 of every machine cycle. They are numbered from 0 within an instruction, and a fetch is kept only while its number is below the instruction length. The other fetches are dummy reads that re-read the next opcode and discard it. The data-move instruction always takes two machine cycles. Its access window crosses the machine-cycle boundary, and program fetches are withheld while the window is open. All outputs are driven straight from flip-flops.

Top module: `mcs_fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs show S1P1 (`st_idx`=0, `ph2`=0) with `fetch_req`, `fetch_discard`, `pc_inc`, `instr_done` and `data_win` all low. The first clock after `rst` falls holds S1P1 once more, now with a kept opcode fetch, and this starts an instruction.
- R2: Once started, the position advances by one phase per clock, from P1 (`ph2`=0) to P2 (`ph2`=1) to the next state. `st_idx` counts 0 to 5 for S1 to S6, so a machine cycle lasts 12 clocks.
- R3: `fetch_req` is high for exactly one clock at S1P1 and at S4P1 of every machine cycle, and low at all other times. The only exception is given in R8.
- R4: `dec_len`, `dec_cycles` and `dec_xmove` are sampled only on the edge that ends S1P1 of an instruction's first machine cycle. Their values at any other time have no effect. A length of 0 counts as 1. A cycle count of 0 counts as 1, and a count above MAX_CYC (4) counts as MAX_CYC.
- R5: Fetch slot k of an instruction is 2·(machine cycle index) plus 1 when the slot is at S4, where slot 0 is the opcode at S1P1 of the first cycle. The fetch is kept when k < length. Otherwise `fetch_discard` is high with `fetch_req`. A one-byte, two-cycle instruction therefore makes three discarded fetches.
- R6: `pc_inc` is high exactly on clocks with a kept fetch, and low on discarded fetches and on clocks without a fetch.
- R7: `instr_done` is high for one clock, at S6P2 of the instruction's last machine cycle. The following clock is S1P1 of the next instruction, with a kept opcode fetch.
- R8: When `dec_xmove` is captured high, the instruction takes two machine cycles whatever `dec_cycles` holds. `data_win` is high from S4P1 of the first cycle through S3P2 of the second, 12 clocks in all, and no fetch is issued while it is high. The S4 fetch of the second cycle is still issued, and is discarded unless the length exceeds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_len | input | 2 | Decoded instruction length in bytes |
| dec_cycles | input | 3 | Decoded machine-cycle count |
| dec_xmove | input | 1 | Decoded external data-move instruction |
| st_idx | output | 3 | Current state, 0..5 for S1..S6 |
| ph2 | output | 1 | 0 for phase P1, 1 for phase P2 |
| fetch_req | output | 1 | Program byte read strobe |
| fetch_discard | output | 1 | Current fetch is a dummy read whose byte is dropped |
| pc_inc | output | 1 | Program counter advance enable |
| instr_done | output | 1 | Last clock of the instruction |
| data_win | output | 1 | Data-access window of the data-move instruction |

## Verification
The two functions that meet in one clock are the opening of the data window and the S4P1 fetch slot of a data move's first cycle, and again the window and the S1P1 slot of its second cycle. The window must win both times, with `fetch_req` low and `data_win` high. These clocks are reached by running data-move instructions with several cycle and length encodings, including a cycle field of 1 that the window must override. The behavioural model predicts each clock independently and compares all outputs. Junk is driven on the decode inputs at every clock except the capture edge, so any sampling outside that edge shows up as a wrong keep, done or window value.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  // Fixed machine-cycle geometry.
  localparam int STATES_PER_CYCLE = 6;
  localparam int PHASES_PER_STATE = 2;

  // Registered strobe bundle driven by the strobe generator.
  typedef struct packed {
    logic fetch;
    logic discard;
    logic pcinc;
    logic done;
    logic win;
  } strobe_t;
endpackage

// File: rtl/mcs_timebase.sv
// Tick and machine-cycle counters; exposes both current and next position.
module mcs_timebase #(
  parameter int TICKS = 12,
  parameter int CYC_W = 2,
  localparam int TK_W = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] last_cyc,
  output logic [TK_W-1:0]  tick_d,
  output logic [CYC_W-1:0] cyc_d,
  output logic             primed_d,
  output logic             cap_en
);
  localparam logic [TK_W-1:0] LAST_TICK = TK_W'(TICKS - 1);

  logic [TK_W-1:0]  tick_q;
  logic [CYC_W-1:0] cyc_q;
  logic             primed_q;

  always_comb begin
    tick_d   = tick_q;
    cyc_d    = cyc_q;
    primed_d = primed_q;
    if (rst) begin
      tick_d   = '0;
      cyc_d    = '0;
      primed_d = 1'b0;
    end else if (!primed_q) begin
      // first clock after reset: begin an instruction at S1P1
      tick_d   = '0;
      cyc_d    = '0;
      primed_d = 1'b1;
    end else if (tick_q == LAST_TICK) begin
      tick_d = '0;
      cyc_d  = (cyc_q == last_cyc) ? '0 : cyc_q + 1'b1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  assign cap_en = !rst && primed_q && (tick_q == '0) && (cyc_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q   <= '0;
      cyc_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      cyc_q    <= cyc_d;
      primed_q <= primed_d;
    end
  end
endmodule

// File: rtl/mcs_decode_hold.sv
// Captures and normalises the decoded instruction attributes once per instruction.
module mcs_decode_hold #(
  parameter int LEN_W   = 2,
  parameter int CNT_W   = 3,
  parameter int MAX_CYC = 4,
  parameter int CYC_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [LEN_W-1:0] dec_len,
  input  logic [CNT_W-1:0] dec_cycles,
  input  logic             dec_xmove,
  output logic [LEN_W-1:0] len_q,
  output logic [CYC_W-1:0] last_cyc_q,
  output logic             xmove_q
);
  logic [LEN_W-1:0] len_n;
  logic [CYC_W-1:0] last_n;

  always_comb begin
    len_n = (dec_len == '0) ? LEN_W'(1) : dec_len;
    if (dec_xmove)
      last_n = CYC_W'(1);
    else if (dec_cycles == '0)
      last_n = '0;
    else if (int'(dec_cycles) > MAX_CYC)
      last_n = CYC_W'(MAX_CYC - 1);
    else
      last_n = CYC_W'(int'(dec_cycles) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q      <= LEN_W'(1);
      last_cyc_q <= '0;
      xmove_q    <= 1'b0;
    end else if (cap_en) begin
      len_q      <= len_n;
      last_cyc_q <= last_n;
      xmove_q    <= dec_xmove;
    end
  end
endmodule

// File: rtl/mcs_strobe_gen.sv
// Derives registered position and strobes from the next position.
module mcs_strobe_gen
  import mcs_pkg::*;
#(
  parameter int TICKS  = 12,
  parameter int PHASES = 2,
  parameter int CYC_W  = 2,
  parameter int LEN_W  = 2,
  parameter int SLOT_B = 6,
  parameter int ST_W   = 3,
  parameter int PH_W   = 1,
  localparam int TK_W  = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TK_W-1:0]  tick_d,
  input  logic [CYC_W-1:0] cyc_d,
  input  logic             primed_d,
  input  logic [LEN_W-1:0] len_q,
  input  logic [CYC_W-1:0] last_cyc_q,
  input  logic             xmove_q,
  output logic [ST_W-1:0]  st_q,
  output logic [PH_W-1:0]  ph_q,
  output strobe_t          stb_q
);
  localparam logic [TK_W-1:0] LAST_TICK = TK_W'(TICKS - 1);
  localparam logic [TK_W-1:0] SLOT_B_T  = TK_W'(SLOT_B);

  logic          at_a, at_b, in_win, kept;
  logic [CYC_W:0] slot_k;
  strobe_t       stb_n;

  always_comb begin
    at_a   = (tick_d == '0);
    at_b   = (tick_d == SLOT_B_T);
    // window: second half of cycle 0 and first half of cycle 1
    in_win = primed_d && xmove_q &&
             (((cyc_d == '0) && (tick_d >= SLOT_B_T)) ||
              ((cyc_d == CYC_W'(1)) && (tick_d < SLOT_B_T)));
    slot_k = {cyc_d, 1'b0} | {{CYC_W{1'b0}}, at_b};
    kept   = int'(slot_k) < int'(len_q);

    stb_n.fetch   = primed_d && (at_a || at_b) && !in_win;
    stb_n.discard = stb_n.fetch && !kept;
    stb_n.pcinc   = stb_n.fetch && kept;
    stb_n.done    = primed_d && (tick_d == LAST_TICK) && (cyc_d == last_cyc_q);
    stb_n.win     = in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      ph_q  <= '0;
      stb_q <= '0;
    end else begin
      st_q  <= ST_W'(int'(tick_d) / PHASES);
      ph_q  <= PH_W'(int'(tick_d) % PHASES);
      stb_q <= stb_n;
    end
  end
endmodule

// File: rtl/mcs_fetch_seq.sv
// Top: machine-cycle fetch sequencer.
module mcs_fetch_seq
  import mcs_pkg::*;
#(
  parameter int LEN_W   = 2,
  parameter int CNT_W   = 3,
  parameter int MAX_CYC = 4,
  localparam int TICKS  = STATES_PER_CYCLE * PHASES_PER_STATE,
  localparam int SLOT_B = (STATES_PER_CYCLE / 2) * PHASES_PER_STATE,
  localparam int CYC_W  = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1,
  localparam int ST_W   = $clog2(STATES_PER_CYCLE),
  localparam int PH_W   = $clog2(PHASES_PER_STATE),
  localparam int TK_W   = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] dec_len,
  input  logic [CNT_W-1:0] dec_cycles,
  input  logic             dec_xmove,
  output logic [ST_W-1:0]  st_idx,
  output logic [PH_W-1:0]  ph2,
  output logic             fetch_req,
  output logic             fetch_discard,
  output logic             pc_inc,
  output logic             instr_done,
  output logic             data_win
);
  logic [TK_W-1:0]  tick_d;
  logic [CYC_W-1:0] cyc_d;
  logic             primed_d;
  logic             cap_en;
  logic [LEN_W-1:0] len_q;
  logic [CYC_W-1:0] last_cyc_q;
  logic             xmove_q;
  strobe_t          stb_q;

  mcs_timebase #(.TICKS(TICKS), .CYC_W(CYC_W)) tb_i (
    .clk(clk), .rst(rst), .last_cyc(last_cyc_q),
    .tick_d(tick_d), .cyc_d(cyc_d), .primed_d(primed_d), .cap_en(cap_en)
  );

  mcs_decode_hold #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_CYC(MAX_CYC), .CYC_W(CYC_W)) dh_i (
    .clk(clk), .rst(rst), .cap_en(cap_en),
    .dec_len(dec_len), .dec_cycles(dec_cycles), .dec_xmove(dec_xmove),
    .len_q(len_q), .last_cyc_q(last_cyc_q), .xmove_q(xmove_q)
  );

  mcs_strobe_gen #(
    .TICKS(TICKS), .PHASES(PHASES_PER_STATE), .CYC_W(CYC_W), .LEN_W(LEN_W),
    .SLOT_B(SLOT_B), .ST_W(ST_W), .PH_W(PH_W)
  ) sg_i (
    .clk(clk), .rst(rst), .tick_d(tick_d), .cyc_d(cyc_d), .primed_d(primed_d),
    .len_q(len_q), .last_cyc_q(last_cyc_q), .xmove_q(xmove_q),
    .st_q(st_idx), .ph_q(ph2), .stb_q(stb_q)
  );

  assign fetch_req     = stb_q.fetch;
  assign fetch_discard = stb_q.discard;
  assign pc_inc        = stb_q.pcinc;
  assign instr_done    = stb_q.done;
  assign data_win      = stb_q.win;
endmodule

// File: rtl/mcs_fetch_seq_chk.sv
// Property checker bound to the sequencer top.
module mcs_fetch_seq_chk #(
  parameter int ST_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [ST_W-1:0] st_idx,
  input logic            ph2,
  input logic            fetch_req,
  input logic            fetch_discard,
  input logic            pc_inc,
  input logic            instr_done,
  input logic            data_win
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (st_idx == '0 && !ph2 && !fetch_req && !instr_done && !data_win));

  assert_phase_flip_R2: assert property (@(posedge clk) disable iff (rst)
    ph2 |=> !ph2);

  assert_state_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ph2 && st_idx != ST_W'(5)) |=> (int'(st_idx) == int'($past(st_idx)) + 1));

  assert_fetch_slot_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> (!ph2 && (st_idx == '0 || st_idx == ST_W'(3))));

  assert_discard_needs_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_discard |-> fetch_req);

  assert_pc_on_kept_R6: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> (fetch_req && !fetch_discard));

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (st_idx == ST_W'(5) && ph2));

  assert_done_then_opcode_R7: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (st_idx == '0 && !ph2 && pc_inc));

  assert_win_blocks_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    data_win |-> !fetch_req);

  assert_win_opens_s4_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(data_win) |-> (st_idx == ST_W'(3) && !ph2));
endmodule

bind mcs_fetch_seq mcs_fetch_seq_chk #(.ST_W(ST_W)) chk_i (
  .clk(clk), .rst(rst), .st_idx(st_idx), .ph2(ph2), .fetch_req(fetch_req),
  .fetch_discard(fetch_discard), .pc_inc(pc_inc), .instr_done(instr_done),
  .data_win(data_win)
);

// File: tb/mcs_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module mcs_fetch_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] dec_len = '0;
  logic [2:0] dec_cycles = '0;
  logic       dec_xmove = 1'b0;
  logic [2:0] st_idx;
  logic       ph2, fetch_req, fetch_discard, pc_inc, instr_done, data_win;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mcs_fetch_seq dut_i (
    .clk(clk), .rst(rst), .dec_len(dec_len), .dec_cycles(dec_cycles),
    .dec_xmove(dec_xmove), .st_idx(st_idx), .ph2(ph2), .fetch_req(fetch_req),
    .fetch_discard(fetch_discard), .pc_inc(pc_inc), .instr_done(instr_done),
    .data_win(data_win)
  );

  // instruction program: length, cycles, data-move
  int prog_len [10] = '{1, 2, 1, 3, 1, 2, 0, 1, 2, 1};
  int prog_cyc [10] = '{1, 1, 2, 2, 2, 4, 0, 7, 3, 1};
  int prog_xm  [10] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1};

  // reference model state
  int m_t = 0, m_c = 0, m_pr = 0;
  int m_len = 1, m_last = 0, m_xm = 0;
  int pidx = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0d c=%0d)", req, what, act, exp, m_t, m_c);
    end
  endtask

  task automatic compare();
    int e_st, e_ph, e_f, e_d, e_p, e_done, e_w, k, slot;
    string rq;
    if (m_pr == 0) begin
      e_st = 0; e_ph = 0; e_f = 0; e_d = 0; e_p = 0; e_done = 0; e_w = 0;
      rq = "R1";
    end else begin
      e_st = m_t / 2;
      e_ph = m_t % 2;
      e_w = (m_xm != 0) && ((m_c == 0 && m_t >= 6) || (m_c == 1 && m_t < 6));
      slot = (m_t == 0 || m_t == 6);
      k = 2 * m_c + (m_t == 6 ? 1 : 0);
      e_f = slot && !e_w;
      e_d = e_f && (k >= m_len);
      e_p = e_f && (k < m_len);
      e_done = (m_t == 11) && (m_c == m_last);
      rq = "R2";
    end
    chk(rq, "st_idx", int'(st_idx), e_st);
    chk(rq, "ph2", int'(ph2), e_ph);
    chk(e_w ? "R8" : "R3", "fetch_req", int'(fetch_req), e_f);
    chk("R4 R5", "fetch_discard", int'(fetch_discard), e_d);
    chk("R6", "pc_inc", int'(pc_inc), e_p);
    chk("R7", "instr_done", int'(instr_done), e_done);
    chk("R8", "data_win", int'(data_win), e_w);
  endtask

  task automatic model_step();
    if (rst) begin
      m_t = 0; m_c = 0; m_pr = 0; m_len = 1; m_last = 0; m_xm = 0;
    end else if (m_pr == 0) begin
      m_pr = 1; m_t = 0; m_c = 0;
    end else begin
      if (m_t == 0 && m_c == 0) begin
        m_len = (dec_len == 0) ? 1 : int'(dec_len);
        m_xm = int'(dec_xmove);
        if (dec_xmove) m_last = 1;
        else if (dec_cycles == 0) m_last = 0;
        else if (dec_cycles > 4) m_last = 3;
        else m_last = int'(dec_cycles) - 1;
      end
      if (m_t == 11) begin
        m_t = 0;
        m_c = (m_c == m_last) ? 0 : m_c + 1;
      end else begin
        m_t = m_t + 1;
      end
    end
  endtask

  initial begin
    for (int n = 0; n < 900; n++) begin
      @(negedge clk);
      if (n > 0) compare();
      // reset for the first cycles and once mid-run (R1)
      rst = (n < 3) || (n >= 420 && n < 423);
      if (m_pr != 0 && m_t == 0 && m_c == 0 && !rst) begin
        dec_len    = 2'(prog_len[pidx]);
        dec_cycles = 3'(prog_cyc[pidx]);
        dec_xmove  = prog_xm[pidx] != 0;
        pidx = (pidx + 1) % 10;
      end else begin
        // junk outside the capture edge must be ignored (R4)
        dec_len    = 2'(n * 3 + 1);
        dec_cycles = 3'(n * 5 + 2);
        dec_xmove  = ((n * 7) % 3) == 0;
      end
      model_step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired, R2 sequence never completed: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule